// File: doc/BRIEF.md
# Programmable Baud Tick Generator Bank

This block produces the bit-rate timing for a group of serial channels. A shared half-rate base tick, one pulse every two core clocks, feeds a set of identical generators. Each generator divides the base tick by a programmed ratio and drives two outputs: a single-cycle tick pulse that serves as a clock enable, and a square clock with 50% duty cycle that runs at half the tick rate.

Each generator has its own 32-bit control word. The word holds an enable bit, a bit that places a divide-by-16 prescaler ahead of the main divider, and a 12-bit field that stores the division ratio minus one. When the prescaler is bypassed, the hardware only divides by even ratios, and it raises an odd ratio to the next even value. A new word written while a generator runs is held back until that generator's next terminal count, so a rate change produces no short pulse. A word whose enable bit is clear stops the generator at once.

Top module: `baud_gen_bank`

## Requirements
- R1: After reset, and until a control word is written, every tick and square clock output is low.
- R2: Control word layout: bit 0 is enable, bit 1 is the divide-by-16 select, and bits 13:2 hold ratio N minus one. With enable set and the prescaler off, an even N gives one single-cycle tick every 2*N core cycles.
- R3: With the prescaler off, an odd N (field value even) is raised to N+1. The tick period is then 2*(N+1) core cycles. Field 0 therefore gives a period of 4.
- R4: With the divide-by-16 select set, N is used unchanged, odd or even, and the tick period is 32*N core cycles.
- R5: Writing a word with enable clear forces the tick and the square clock low from the next cycle. The counters then stay idle and produce no further tick.
- R6: A word with enable set, written while the generator runs, takes effect at the generator's next terminal count. The interval that ends at that tick keeps the old period, and the interval after it uses the new period.
- R7: The square clock changes state in exactly the cycles in which the tick is high, so it holds 50% duty at half the tick rate.
- R8: Generators are independent: writing one generator's word leaves the period of every other generator unchanged.
- R9: The largest field value, 4095 with the prescaler off, gives a tick period of 8192 core cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NUM_GEN | One-hot write strobe that selects the generator receiving cfg_word |
| cfg_word | input | 32 | Control word: enable, divide-by-16 select, ratio minus one |
| tick | output | NUM_GEN | Single-cycle divided tick, one bit per generator |
| sq_clk | output | NUM_GEN | 50% duty square clock, one bit per generator |

## Verification
The bench targets the even-rounding rule with an odd ratio and with field 0. A design without the rounding would give periods of 10 and 2 instead of 12 and 4. With the prescaler on, an odd ratio must stay odd; a design that rounds in both modes would give 128 instead of 96. For the reconfiguration made in mid-run, the bench measures the interval that straddles the write. An immediate reload would show a truncated interval, while a missed reload would keep the old period afterwards. The bench also checks that disabling stops the outputs at once, that the square clock flips at every tick, that a write to one generator leaves another alone, and that the maximum field gives the full 8192-cycle period without overflow.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int DIV_W  = 12;
    localparam int WORD_W = 32;
    localparam int PRE_W  = 4;

    typedef struct packed {
        logic [DIV_W-1:0] field;
        logic             pre16;
        logic             en;
    } bt_cfg_t;

    function automatic bt_cfg_t bt_decode(input logic [WORD_W-1:0] w);
        bt_cfg_t c;
        c.en    = w[0];
        c.pre16 = w[1];
        c.field = w[DIV_W+1:2];
        return c;
    endfunction

    // Terminal count value: the ratio minus one, made odd (even ratio)
    // when the prescaler is bypassed.
    function automatic logic [DIV_W-1:0] bt_limit(input bt_cfg_t c);
        return c.pre16 ? c.field : (c.field | {{(DIV_W-1){1'b0}}, 1'b1});
    endfunction
endpackage

// File: rtl/bt_halfrate.sv
module bt_halfrate (
    input  logic clk,
    input  logic rst,
    output logic base_en
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign base_en = phase_q;
endmodule

// File: rtl/bt_channel.sv
module bt_channel
    import bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_en,
    input  logic              we,
    input  logic [WORD_W-1:0] word,
    output logic              tick,
    output logic              sq
);
    bt_cfg_t          act_q, pend_q, wr_cfg;
    logic             pend_v_q;
    logic [PRE_W-1:0] pre_q;
    logic [DIV_W-1:0] cnt_q;
    logic             tick_q, sq_q;
    logic             step, tc;

    assign wr_cfg = bt_decode(word);
    assign step   = act_q.en && base_en &&
                    (!act_q.pre16 || pre_q == {PRE_W{1'b1}});
    assign tc     = step && (cnt_q == bt_limit(act_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
            pre_q    <= '0;
            cnt_q    <= '0;
            tick_q   <= 1'b0;
            sq_q     <= 1'b0;
        end else begin
            tick_q <= tc;
            if (tc)
                sq_q <= ~sq_q;
            if (base_en && act_q.en && act_q.pre16)
                pre_q <= pre_q + 1'b1;
            if (step)
                cnt_q <= tc ? '0 : cnt_q + 1'b1;

            if (we) begin
                if (!wr_cfg.en || !act_q.en) begin
                    act_q    <= wr_cfg;
                    pend_v_q <= 1'b0;
                    pre_q    <= '0;
                    cnt_q    <= '0;
                    tick_q   <= 1'b0;
                    sq_q     <= 1'b0;
                end else begin
                    pend_q   <= wr_cfg;
                    pend_v_q <= 1'b1;
                end
            end else if (tc && pend_v_q) begin
                act_q    <= pend_q;
                pend_v_q <= 1'b0;
                pre_q    <= '0;
                cnt_q    <= '0;
            end
        end
    end

    assign tick = tick_q;
    assign sq   = sq_q;
endmodule

// File: rtl/baud_gen_bank.sv
module baud_gen_bank
    import bt_pkg::*;
#(
    parameter int NUM_GEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GEN-1:0] cfg_we,
    input  logic [WORD_W-1:0]  cfg_word,
    output logic [NUM_GEN-1:0] tick,
    output logic [NUM_GEN-1:0] sq_clk
);
    logic base_en;

    bt_halfrate u_half (
        .clk    (clk),
        .rst    (rst),
        .base_en(base_en)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        bt_channel u_chan (
            .clk    (clk),
            .rst    (rst),
            .base_en(base_en),
            .we     (cfg_we[g]),
            .word   (cfg_word),
            .tick   (tick[g]),
            .sq     (sq_clk[g])
        );
    end
endmodule

// File: rtl/bt_checker.sv
module bt_checker
    import bt_pkg::*;
#(
    parameter int NUM_GEN = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_GEN-1:0] cfg_we,
    input logic [WORD_W-1:0]  cfg_word,
    input logic [NUM_GEN-1:0] tick,
    input logic [NUM_GEN-1:0] sq_clk
);
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        assert_single_tick_R2: assert property (@(posedge clk) disable iff (rst)
            tick[g] |=> !tick[g]);

        assert_disable_stops_R5: assert property (@(posedge clk) disable iff (rst)
            (cfg_we[g] && !cfg_word[0]) |=> (!tick[g] && !sq_clk[g]));

        assert_sq_flips_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
            tick[g] |-> (sq_clk[g] != $past(sq_clk[g])));

        assert_sq_steady_R7: assert property (@(posedge clk) disable iff (rst)
            (!tick[g] && !$past(cfg_we[g])) |-> $stable(sq_clk[g]));
    end
endmodule

bind baud_gen_bank bt_checker #(.NUM_GEN(NUM_GEN)) u_bt_checker (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_word(cfg_word),
    .tick    (tick),
    .sq_clk  (sq_clk)
);

// File: tb/sim_baud_gen_bank.sv
module sim_baud_gen_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NG         = 4;
    localparam int WAIT_LIM   = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NG-1:0] cfg_we = '0;
    logic [31:0]   cfg_word = '0;
    logic [NG-1:0] tick, sq_clk;

    int checks = 0;
    int fails  = 0;

    baud_gen_bank #(.NUM_GEN(NG)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .tick(tick), .sq_clk(sq_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic en, input logic p16, input int field);
        logic [11:0] f;
        f = field[11:0];
        return {18'd0, f, p16, en};
    endfunction

    task automatic wr(input int g, input logic [31:0] w);
        @(negedge clk);
        cfg_we   = '0;
        cfg_we[g] = 1'b1;
        cfg_word = w;
        @(negedge clk);
        cfg_we   = '0;
    endtask

    // returns at a negedge where tick[g] is high; n = cycles waited
    task automatic wait_tick(input int g, output int n);
        n = 0;
        while (!tick[g] && n < WAIT_LIM) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic period(input int g, output int per, output logic flip);
        int n;
        logic s0;
        wait_tick(g, n);
        s0 = sq_clk[g];
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!tick[g] && per < WAIT_LIM);
        flip = (sq_clk[g] != s0);
    endtask

    task automatic t_reset();
        int bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (tick != '0 || sq_clk != '0) bad++;
        end
        chk(bad == 0, "R1 outputs low after reset", bad, 0);
    endtask

    task automatic t_even();
        int p; logic fl;
        wr(0, mk(1'b1, 1'b0, 3));
        period(0, p, fl);
        chk(p == 8, "R2 even ratio 4 period", p, 8);
        chk(fl, "R7 square clock flips per tick", fl, 1);
        period(0, p, fl);
        chk(p == 8, "R2 even ratio 4 repeat", p, 8);
        chk(fl, "R7 square clock flips again", fl, 1);
    endtask

    task automatic t_odd();
        int p; logic fl;
        wr(1, mk(1'b1, 1'b0, 4));
        period(1, p, fl);
        chk(p == 12, "R3 odd ratio 5 rounded to 6", p, 12);
        wr(1, mk(1'b0, 1'b0, 0));
        wr(1, mk(1'b1, 1'b0, 0));
        period(1, p, fl);
        chk(p == 4, "R3 field 0 rounded to ratio 2", p, 4);
    endtask

    task automatic t_pre16();
        int p; logic fl;
        wr(2, mk(1'b1, 1'b1, 2));
        period(2, p, fl);
        chk(p == 96, "R4 prescaler odd ratio 3 unchanged", p, 96);
        wr(2, mk(1'b0, 1'b0, 0));
        wr(2, mk(1'b1, 1'b1, 0));
        period(2, p, fl);
        chk(p == 32, "R4 prescaler ratio 1", p, 32);
    endtask

    task automatic t_indep();
        int p; logic fl;
        wr(2, mk(1'b0, 1'b0, 0));
        wr(3, mk(1'b1, 1'b1, 1));
        period(0, p, fl);
        chk(p == 8, "R8 gen0 unaffected by gen3 write", p, 8);
        period(3, p, fl);
        chk(p == 64, "R8 gen3 prescaled ratio 2", p, 64);
        wr(3, mk(1'b0, 1'b0, 0));
    endtask

    task automatic t_reconfig();
        int n, p;
        logic fl;
        wait_tick(0, n);
        cfg_we    = '0;
        cfg_we[0] = 1'b1;
        cfg_word  = mk(1'b1, 1'b0, 9);
        @(negedge clk);
        cfg_we = '0;
        n = 1;
        while (!tick[0] && n < WAIT_LIM) begin
            @(negedge clk);
            n++;
        end
        chk(n == 8, "R6 interval spanning write keeps old period", n, 8);
        period(0, p, fl);
        chk(p == 20, "R6 new period after terminal count", p, 20);
    endtask

    task automatic t_disable();
        int n, bad;
        wait_tick(0, n);
        cfg_we    = '0;
        cfg_we[0] = 1'b1;
        cfg_word  = mk(1'b0, 1'b0, 9);
        @(negedge clk);
        cfg_we = '0;
        chk(tick[0] == 1'b0 && sq_clk[0] == 1'b0, "R5 outputs low after disable",
            {tick[0], sq_clk[0]}, 0);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (tick[0] || sq_clk[0]) bad++;
        end
        chk(bad == 0, "R5 no tick while disabled", bad, 0);
    endtask

    task automatic t_max();
        int p; logic fl;
        wr(1, mk(1'b0, 1'b0, 0));
        wr(1, mk(1'b1, 1'b0, 4095));
        period(1, p, fl);
        chk(p == 8192, "R9 maximum field period", p, 8192);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_even();
        t_odd();
        t_pre16();
        t_indep();
        t_reconfig();
        t_disable();
        t_max();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule